// File: doc/BRIEF.md
# Low-Rate Serial Receiver With Two-Stage Frame Holding

This block is the receive half of a low-power asynchronous serial port. It is clocked only by a slow reference clock, nominally 32.768 kHz, and uses nothing faster to oversample the line. When software turns it on, it watches the line for a falling edge. It checks that the start bit is still low at mid-bit. It then samples each data bit once, near its middle, and collects a frame of eight or nine data bits, least significant bit first.

A finished frame goes to a holding register and then to a one-entry buffer that software reads. When the buffer is occupied, the holding register keeps the frame until space frees up. The held frame is dropped only if yet another frame begins. Software has two consuming read ports, one narrow and one extended, and one peek port that leaves the buffer untouched. Level flags show data availability. Sticky flags record overflow and underflow and are cleared by writing ones.

Top module: `slow_uart_rx`

## Requirements
- R1: After reset the receiver is disabled and every flag output is 0. A `cmd_en_i` pulse sets `stat_rxens_o` from the next cycle on. A `cmd_dis_i` pulse clears it. When both pulse in the same cycle, the receiver ends up disabled.
- R2: While enabled, a high-to-low change on `rx_i` begins a frame. The line is sampled once per bit period of `cfg_period_i` cycles (at least 4), near mid-bit. A start bit that is high again at its mid-bit sample is dropped and produces no frame. While disabled, line activity produces no frame.
- R3: Data bits arrive least significant bit first. `cfg_nine_i`=1 selects nine data bits and `cfg_nine_i`=0 selects eight, in which case the top data bit reads as 0. A stop bit sampled low sets the frame's error bit `rdx_ferr_o`/`pk_ferr_o` to 1.
- R4: A finished frame reaches the buffer, and `stat_datav_o` and `if_datav_o` become 1. If the buffer is occupied, the frame waits in the holding register and moves into the buffer on the cycle after the buffer is read.
- R5: A confirmed start bit that arrives while both the holding register and the buffer are occupied discards the held frame and sets `if_of_o`. The buffered frame is kept, and the new frame takes the place of the discarded one.
- R6: A `cmd_dis_i` pulse in the middle of a frame discards that partial frame. No data from it ever reaches the buffer.
- R7: While `rd_i` is high, `rd_data_o` carries the low eight bits of the buffered frame. While `rdx_i` is high, `rdx_data_o` carries all nine bits and `rdx_ferr_o` carries the error bit. A cycle with either strobe removes the frame from the buffer.
- R8: A consuming read of an empty buffer sets `if_uf_o`. While `pk_i` is high, `pk_data_o`/`pk_ferr_o` show the buffered frame. A peek never removes the frame and never sets `if_uf_o`.
- R9: `if_of_o` and `if_uf_o` stay set until a write-one-to-clear: bit 0 of `ifc_i` clears overflow and bit 1 clears underflow. A set event in the same cycle wins over the clear.
- R10: `stat_datav_o` and `if_datav_o` return to 0 once a read empties the buffer, provided no frame is waiting behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| cfg_nine_i | input | 1 | 1: nine data bits, 0: eight |
| cfg_period_i | input | PER_W | Bit period in clock cycles (at least 4) |
| cmd_en_i | input | 1 | Enable command pulse |
| cmd_dis_i | input | 1 | Disable command pulse |
| rd_i | input | 1 | Consuming narrow read strobe |
| rdx_i | input | 1 | Consuming extended read strobe |
| pk_i | input | 1 | Non-consuming peek strobe |
| ifc_i | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 underflow |
| rd_data_o | output | DATA_W-1 | Low bits of buffered frame during `rd_i` |
| rdx_data_o | output | DATA_W | Full buffered frame during `rdx_i` |
| rdx_ferr_o | output | 1 | Stop-bit error of buffered frame during `rdx_i` |
| pk_data_o | output | DATA_W | Full buffered frame during `pk_i` |
| pk_ferr_o | output | 1 | Stop-bit error of buffered frame during `pk_i` |
| stat_rxens_o | output | 1 | Receiver enabled |
| stat_datav_o | output | 1 | Buffer holds a frame (status) |
| if_datav_o | output | 1 | Buffer holds a frame (interrupt flag) |
| if_of_o | output | 1 | Sticky overflow flag |
| if_uf_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with DATA_W=9, PER_W=6 and SYNC_STAGES=2. A 6-bit period field keeps frames down to a few dozen cycles, so the full hold-then-overwrite sequence and the disable-mid-frame case fit into a short run. Most frames use a period of 8. One frame uses a period of 5, which checks the rounding of the odd mid-bit point. Two resynchronisation stages put the real input latency between the line and the bit counter, so the mid-bit placement is checked under realistic delay.

// File: rtl/slow_uart_rx_pkg.sv
`timescale 1ns/1ps
package slow_uart_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   localparam int unsigned FLAG_OF_BIT = 0;
   localparam int unsigned FLAG_UF_BIT = 1;

endpackage

// File: rtl/slow_uart_rx_sampler.sv
`timescale 1ns/1ps
module slow_uart_rx_sampler #(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned PER_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              cfg_nine_i,
   input  logic [PER_W-1:0]  cfg_period_i,
   input  logic              cmd_en_i,
   input  logic              cmd_dis_i,
   output logic              rxens_o,
   output logic              start_ok_o,
   output logic              done_o,
   output logic [DATA_W-1:0] frame_o,
   output logic              ferr_o
);
   import slow_uart_rx_pkg::*;

   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam logic [PER_W-1:0] CNT_ONE = 1;
   localparam logic [PER_W-1:0] CNT_TWO = 2;
   localparam logic [IDX_W-1:0] IDX_ONE = 1;
   localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(DATA_W - 2);

   // ---------------- line resynchronisation ----------------
   logic [SYNC_STAGES:0] sync_chain;
   logic                 rx_s;
   assign sync_chain[0] = rx_i;

   for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_chain[gi+1] <= 1'b1;
         else        sync_chain[gi+1] <= sync_chain[gi];
      end
   end
   assign rx_s = sync_chain[SYNC_STAGES];

   // ---------------- state ----------------
   rx_state_e         state_q;
   logic [PER_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              en_q;
   logic              rx_prev_q;

   logic [PER_W:0]    per_p1;
   logic [PER_W-1:0]  mid_load;
   logic [IDX_W-1:0]  last_idx;
   logic              run;
   logic              tick;
   logic              fall;

   // Start bit mid-point: first sample lands on line cycle (P+1)/2,
   // which is two cycles after the counter load, independent of SYNC_STAGES.
   assign per_p1   = {1'b0, cfg_period_i} + {{PER_W{1'b0}}, 1'b1};
   assign mid_load = per_p1[PER_W:1] - CNT_TWO;
   assign last_idx = cfg_nine_i ? LAST_WIDE : LAST_NARROW;
   assign run      = en_q && !cmd_dis_i;
   assign tick     = (cnt_q == '0);
   assign fall     = rx_prev_q && !rx_s;

   assign start_ok_o = run && (state_q == ST_START) && tick && !rx_s;
   assign done_o     = run && (state_q == ST_STOP) && tick;
   assign ferr_o     = !rx_s;
   assign rxens_o    = en_q;

   // In narrow mode the frame sits one place high in the shift register.
   assign frame_o = cfg_nine_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         rx_prev_q <= 1'b1;
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         sh_q      <= '0;
      end else begin
         rx_prev_q <= rx_s;
         if (cmd_dis_i)     en_q <= 1'b0;
         else if (cmd_en_i) en_q <= 1'b1;

         if (!run) begin
            state_q <= ST_IDLE;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (fall) begin
                     state_q <= ST_START;
                     cnt_q   <= mid_load;
                  end
               end
               ST_START: begin
                  if (!tick) begin
                     cnt_q <= cnt_q - CNT_ONE;
                  end else if (!rx_s) begin
                     state_q <= ST_DATA;
                     cnt_q   <= cfg_period_i - CNT_ONE;
                     idx_q   <= '0;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
               ST_DATA: begin
                  if (!tick) begin
                     cnt_q <= cnt_q - CNT_ONE;
                  end else begin
                     sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                     cnt_q <= cfg_period_i - CNT_ONE;
                     if (idx_q == last_idx) state_q <= ST_STOP;
                     else                   idx_q   <= idx_q + IDX_ONE;
                  end
               end
               ST_STOP: begin
                  if (!tick) cnt_q   <= cnt_q - CNT_ONE;
                  else       state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_DIS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_dis_i |=> (state_q == ST_IDLE) && !rxens_o); // R6

   AST_EN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en_i && !cmd_dis_i) |=> rxens_o); // R1

endmodule

// File: rtl/slow_uart_rx_hold.sv
`timescale 1ns/1ps
module slow_uart_rx_hold #(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] frame_i,
   input  logic              ferr_i,
   input  logic              pop_i,
   output logic              buf_valid_o,
   output logic [DATA_W-1:0] buf_data_o,
   output logic              buf_ferr_o,
   output logic              of_evt_o,
   output logic              uf_evt_o
);
   localparam int unsigned ENT_W = DATA_W + 1;

   logic [ENT_W-1:0] hold_q;
   logic             hold_full_q;
   logic [ENT_W-1:0] buf_q;
   logic             buf_valid_q;
   logic             move;

   assign move     = hold_full_q && (!buf_valid_q || pop_i);
   assign of_evt_o = start_ok_i && hold_full_q && buf_valid_q && !pop_i;
   assign uf_evt_o = pop_i && !buf_valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else if (done_i) begin
         hold_q      <= {ferr_i, frame_i};
         hold_full_q <= 1'b1;
      end else if (move || of_evt_o) begin
         hold_full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q       <= '0;
         buf_valid_q <= 1'b0;
      end else if (move) begin
         buf_q       <= hold_q;
         buf_valid_q <= 1'b1;
      end else if (pop_i) begin
         buf_valid_q <= 1'b0;
      end
   end

   assign buf_valid_o = buf_valid_q;
   assign buf_data_o  = buf_q[DATA_W-1:0];
   assign buf_ferr_o  = buf_q[DATA_W];

   AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full_q && buf_valid_q && !pop_i && !start_ok_i && !done_i)
      |=> hold_full_q && $stable(hold_q)); // R4

   AST_OVERWRITE_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      of_evt_o |=> buf_valid_q && $stable(buf_q)); // R5

   AST_EMPTY_POP_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !buf_valid_q && !hold_full_q) |=> !buf_valid_q); // R8

   AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && buf_valid_q && !hold_full_q) |=> !buf_valid_q); // R10

endmodule

// File: rtl/slow_uart_rx_flags.sv
`timescale 1ns/1ps
module slow_uart_rx_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       of_evt_i,
   input  logic       uf_evt_i,
   input  logic [1:0] clr_i,
   output logic       of_o,
   output logic       uf_o
);
   import slow_uart_rx_pkg::*;

   logic of_q;
   logic uf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         of_q <= 1'b0;
         uf_q <= 1'b0;
      end else begin
         of_q <= (of_q && !clr_i[FLAG_OF_BIT]) || of_evt_i;
         uf_q <= (uf_q && !clr_i[FLAG_UF_BIT]) || uf_evt_i;
      end
   end

   assign of_o = of_q;
   assign uf_o = uf_q;

   AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (of_q && !clr_i[FLAG_OF_BIT]) |=> of_q); // R9

   AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt_i |=> uf_q); // R8

   AST_OF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      of_evt_i |=> of_q); // R5

endmodule

// File: rtl/slow_uart_rx.sv
`timescale 1ns/1ps
module slow_uart_rx #(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned PER_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              cfg_nine_i,
   input  logic [PER_W-1:0]  cfg_period_i,
   input  logic              cmd_en_i,
   input  logic              cmd_dis_i,
   input  logic              rd_i,
   input  logic              rdx_i,
   input  logic              pk_i,
   input  logic [1:0]        ifc_i,
   output logic [DATA_W-2:0] rd_data_o,
   output logic [DATA_W-1:0] rdx_data_o,
   output logic              rdx_ferr_o,
   output logic [DATA_W-1:0] pk_data_o,
   output logic              pk_ferr_o,
   output logic              stat_rxens_o,
   output logic              stat_datav_o,
   output logic              if_datav_o,
   output logic              if_of_o,
   output logic              if_uf_o
);
   // ---------------- elaboration checks ----------------
   if (DATA_W != 9) begin : g_bad_data_w
      $error("slow_uart_rx: DATA_W must be 9");
   end
   if (PER_W < 3) begin : g_bad_per_w
      $error("slow_uart_rx: PER_W must be at least 3");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("slow_uart_rx: SYNC_STAGES must be 0 to 3");
   end

   logic              start_ok;
   logic              done;
   logic [DATA_W-1:0] frame;
   logic              ferr;
   logic              pop;
   logic              buf_valid;
   logic [DATA_W-1:0] buf_data;
   logic              buf_ferr;
   logic              of_evt;
   logic              uf_evt;

   assign pop = rd_i || rdx_i;

   slow_uart_rx_sampler #(
      .DATA_W      (DATA_W),
      .PER_W       (PER_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_sampler (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_i         (rx_i),
      .cfg_nine_i   (cfg_nine_i),
      .cfg_period_i (cfg_period_i),
      .cmd_en_i     (cmd_en_i),
      .cmd_dis_i    (cmd_dis_i),
      .rxens_o      (stat_rxens_o),
      .start_ok_o   (start_ok),
      .done_o       (done),
      .frame_o      (frame),
      .ferr_o       (ferr)
   );

   slow_uart_rx_hold #(
      .DATA_W (DATA_W)
   ) i_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_ok_i  (start_ok),
      .done_i      (done),
      .frame_i     (frame),
      .ferr_i      (ferr),
      .pop_i       (pop),
      .buf_valid_o (buf_valid),
      .buf_data_o  (buf_data),
      .buf_ferr_o  (buf_ferr),
      .of_evt_o    (of_evt),
      .uf_evt_o    (uf_evt)
   );

   slow_uart_rx_flags i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .of_evt_i (of_evt),
      .uf_evt_i (uf_evt),
      .clr_i    (ifc_i),
      .of_o     (if_of_o),
      .uf_o     (if_uf_o)
   );

   // Read ports return zero when not selected, as on a register read mux.
   assign rd_data_o    = rd_i  ? buf_data[DATA_W-2:0] : '0;
   assign rdx_data_o   = rdx_i ? buf_data : '0;
   assign rdx_ferr_o   = rdx_i && buf_ferr;
   assign pk_data_o    = pk_i  ? buf_data : '0;
   assign pk_ferr_o    = pk_i  && buf_ferr;
   assign stat_datav_o = buf_valid;
   assign if_datav_o   = buf_valid;

   AST_PEEK_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_i && !pop && !if_uf_o) |=> !if_uf_o); // R8

   AST_PEEK_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_i && !pop && stat_datav_o) |=> stat_datav_o); // R8

endmodule

// File: tb/test_slow_uart_rx.sv
`timescale 1ns/1ps
module test_slow_uart_rx;

   localparam int unsigned DATA_W = 9;
   localparam int unsigned PER_W  = 6;
   localparam int unsigned SYNC   = 2;

   // {nine, stop level, data[8:0]}
   localparam logic [10:0] VEC [0:7] = '{
      11'h2A5, 11'h7C3, 11'h3FF, 11'h700,
      11'h055, 11'h4F0, 11'h600, 11'h280
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx = 1'b1;
   logic              nine = 1'b1;
   logic [PER_W-1:0]  period = 6'd8;
   logic              cmd_en = 1'b0;
   logic              cmd_dis = 1'b0;
   logic              rd = 1'b0;
   logic              rdx = 1'b0;
   logic              pk = 1'b0;
   logic [1:0]        ifc = 2'b00;
   logic [DATA_W-2:0] rd_data;
   logic [DATA_W-1:0] rdx_data;
   logic              rdx_ferr;
   logic [DATA_W-1:0] pk_data;
   logic              pk_ferr;
   logic              rxens;
   logic              datav;
   logic              if_datav;
   logic              if_of;
   logic              if_uf;

   int checks = 0;
   int errors = 0;
   bit done_run = 1'b0;

   always #10 clk = ~clk;

   slow_uart_rx #(
      .DATA_W (DATA_W), .PER_W (PER_W), .SYNC_STAGES (SYNC)
   ) i_slow_uart_rx (
      .clk (clk), .rst_n (rst_n), .rx_i (rx),
      .cfg_nine_i (nine), .cfg_period_i (period),
      .cmd_en_i (cmd_en), .cmd_dis_i (cmd_dis),
      .rd_i (rd), .rdx_i (rdx), .pk_i (pk), .ifc_i (ifc),
      .rd_data_o (rd_data), .rdx_data_o (rdx_data), .rdx_ferr_o (rdx_ferr),
      .pk_data_o (pk_data), .pk_ferr_o (pk_ferr),
      .stat_rxens_o (rxens), .stat_datav_o (datav), .if_datav_o (if_datav),
      .if_of_o (if_of), .if_uf_o (if_uf)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hold_line(input logic v);
      rx = v;
      cycles(int'(period));
   endtask

   task automatic send(input logic [8:0] d, input logic stopv);
      hold_line(1'b0);
      for (int b = 0; b < (nine ? 9 : 8); b++) hold_line(d[b]);
      hold_line(stopv);
      rx = 1'b1;
      cycles(4);
   endtask

   task automatic pulse_en();
      cmd_en = 1'b1; cycles(1); cmd_en = 1'b0;
   endtask

   task automatic pulse_dis();
      cmd_dis = 1'b1; cycles(1); cmd_dis = 1'b0;
   endtask

   task automatic pop_x(input string req, input logic [8:0] exp_d, input logic exp_f);
      rdx = 1'b1; #1;
      check(req, 32'(rdx_data), 32'(exp_d));
      check(req, 32'(rdx_ferr), 32'(exp_f));
      cycles(1); rdx = 1'b0;
   endtask

   initial begin
      cycles(3);
      // R1: reset state
      check("R1 reset rxens", 32'(rxens), 0);
      check("R1 reset datav", 32'({datav, if_datav, if_of, if_uf}), 0);
      rst_n = 1'b1;
      cycles(2);

      // R2: line ignored while disabled
      send(9'h155, 1'b1);
      check("R2 disabled no frame", 32'(datav), 0);

      // R1: enable, then simultaneous enable/disable
      pulse_en();
      check("R1 enabled", 32'(rxens), 1);
      cmd_en = 1'b1; cmd_dis = 1'b1; cycles(1); cmd_en = 1'b0; cmd_dis = 1'b0;
      check("R1 disable wins", 32'(rxens), 0);
      pulse_en();

      // R2: short glitch is not a start bit
      rx = 1'b0; cycles(1); rx = 1'b1;
      cycles(3 * int'(period));
      check("R2 glitch rejected", 32'(datav), 0);

      // R3/R7: vector table
      for (int v = 0; v < 8; v++) begin
         logic [8:0] d;
         logic [8:0] exp_d;
         d = VEC[v][8:0];
         nine = VEC[v][10];
         exp_d = nine ? d : {1'b0, d[7:0]};
         send(d, VEC[v][9]);
         check("R4 datav after frame", 32'({datav, if_datav}), 32'h3);
         pk = 1'b1; #1;
         check("R8 peek data", 32'(pk_data), 32'(exp_d));
         check("R3 peek ferr", 32'(pk_ferr), 32'(!VEC[v][9]));
         cycles(1); pk = 1'b0;
         check("R8 peek keeps frame", 32'(datav), 1);
         if (v % 2 == 0) begin
            rd = 1'b1; #1;
            check("R7 narrow read", 32'(rd_data), 32'(d[7:0]));
            cycles(1); rd = 1'b0;
         end else begin
            pop_x("R3 R7 extended read", exp_d, !VEC[v][9]);
         end
         check("R10 datav cleared", 32'({datav, if_datav}), 0);
      end
      check("R8 no underflow from reads", 32'(if_uf), 0);
      nine = 1'b1;

      // R4: second frame waits behind a full buffer
      send(9'h011, 1'b1);
      send(9'h122, 1'b1);
      check("R4 no overflow yet", 32'(if_of), 0);
      pop_x("R4 first frame", 9'h011, 1'b0);
      check("R4 held frame moved", 32'(datav), 1);
      pop_x("R4 held frame", 9'h122, 1'b0);
      check("R10 empty after both", 32'(datav), 0);

      // R5: third frame overwrites the held one
      send(9'h0A1, 1'b1);
      send(9'h0B2, 1'b1);
      send(9'h1C3, 1'b1);
      check("R5 overflow flag", 32'(if_of), 1);
      pop_x("R5 buffer kept", 9'h0A1, 1'b0);
      pop_x("R5 newest replaced held", 9'h1C3, 1'b0);
      check("R5 empty after", 32'(datav), 0);

      // R9: overflow sticky, then W1C
      cycles(3);
      check("R9 overflow sticky", 32'(if_of), 1);
      ifc = 2'b01; cycles(1); ifc = 2'b00;
      check("R9 overflow cleared", 32'(if_of), 0);

      // R8: underflow on empty consuming read, none on peek
      rd = 1'b1; cycles(1); rd = 1'b0;
      check("R8 underflow set", 32'(if_uf), 1);
      ifc = 2'b10; cycles(1); ifc = 2'b00;
      check("R9 underflow cleared", 32'(if_uf), 0);
      pk = 1'b1; cycles(2); pk = 1'b0;
      check("R8 peek empty no underflow", 32'(if_uf), 0);
      rdx = 1'b1; ifc = 2'b10; cycles(1); rdx = 1'b0; ifc = 2'b00;
      check("R9 set wins over clear", 32'(if_uf), 1);
      ifc = 2'b10; cycles(1); ifc = 2'b00;

      // R6: disable in the middle of a frame
      hold_line(1'b0);
      hold_line(1'b1);
      hold_line(1'b0);
      pulse_dis();
      for (int b = 0; b < 7; b++) hold_line(1'b1);
      hold_line(1'b1);
      cycles(4);
      check("R6 partial discarded", 32'(datav), 0);
      check("R6 rxens off", 32'(rxens), 0);
      pulse_en();
      send(9'h05A, 1'b1);
      pop_x("R6 clean frame after re-enable", 9'h05A, 1'b0);

      // R2/R3: odd period rounding
      period = 6'd5;
      send(9'h1A5, 1'b1);
      pop_x("R2 odd period frame", 9'h1A5, 1'b0);

      done_run = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule